// File: doc/BRIEF.md
# Router Fault Flag and Drop Counter Monitor

This block watches a packet router that lets two devices share one Ethernet port. The router's FIFOs and arbiters send it single-cycle condition pulses. Each of seven fault conditions latches its own sticky bit. The bits together form a status word, and the `err_any` output is high whenever that word is nonzero. The block also keeps two discard counters. One counts received packets whose length in beats does not match a programmable expected length. The other counts packets dropped because the receive input FIFO was full.

The block observes the receive beat stream and never drives it. A beat counts only in a cycle where both `beat_valid` and `beat_ready` are high. Back-pressure (ready low) simply holds the beat count. The block never stalls the stream.

Software reads through a one-cycle read strobe. Read data is combinational from the current state in the cycle of the strobe. The selected register clears on the clock edge that ends that cycle. A new event in that same cycle survives the clear.

Top module: `pkt_err_monitor`

## Requirements
- R1: A pulse on `err_evt[i]` sets status bit i, and the bit stays set until a status read. The bit map is: 0 link-to-Ethernet clock-crossing FIFO written while full; 1 Ethernet-to-link clock-crossing FIFO written while full; 2 local beam-data arbiter FIFO full; 3 local control-data arbiter FIFO stalled; 4 remote-device arbiter FIFO full; 5 transmit payload FIFO stalled; 6 receive input FIFO written while full.
- R2: `err_any` is high exactly when at least one status bit is set. It rises in the cycle after the first pulse.
- R3: A read with `rd_sel`=0 returns the status bits in `rd_data[6:0]` with zeros above them. All status bits clear at the end of that cycle.
- R4: An `err_evt` bit that pulses in the same cycle as a status read is set after the clear.
- R5: On the last accepted beat of a packet, the rejected counter increments by one if the packet's beat count differs from `exp_len`. It stays unchanged if the count matches. A packet longer than 2^LEN_W-1 beats is always rejected.
- R6: A beat counts toward packet length only when `beat_valid` and `beat_ready` are both high.
- R7: Each cycle with `ovf_drop` high increments the overflow counter by one.
- R8: A read with `rd_sel`=1 returns the rejected count in the upper CNT_W bits and the overflow count in the lower CNT_W bits. Both counters clear at the end of that cycle.
- R9: An increment in the same cycle as a counter read leaves that counter at 1 after the clear.
- R10: Each counter saturates at all ones.
- R11: After reset, the status word, both counters, and `err_any` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_evt | input | 7 | Fault condition pulses, one per source |
| beat_valid | input | 1 | Receive beat valid (observed) |
| beat_ready | input | 1 | Receive beat ready (observed) |
| beat_last | input | 1 | Receive beat ends a packet |
| exp_len | input | LEN_W | Expected packet length in beats |
| ovf_drop | input | 1 | Packet dropped because input FIFO full |
| rd_en | input | 1 | Read strobe, clears selected register |
| rd_sel | input | 1 | 0 status word, 1 discard counter pair |
| rd_data | output | 2*CNT_W | Read data for the selected register |
| err_any | output | 1 | Status word is nonzero |

## Verification
A read-clear can coincide with a new fault pulse, and it can also coincide with a counter increment. The bench provokes both. It raises `err_evt` patterns or `ovf_drop` and a rejected packet's last beat in the very cycle of the read strobe. It checks that the read data shows only the old state, and that a follow-up read shows exactly the coincident events. Length checking is swept over a grid of expected lengths and actual lengths, with stall cycles between beats. Every one of the 128 status patterns is written and read back.

// File: rtl/pem_pkg.sv
package pem_pkg;
  localparam int NSRC = 7;
  typedef enum logic [2:0] {
    SRC_L2E_CDC   = 3'd0,
    SRC_E2L_CDC   = 3'd1,
    SRC_BEAM_FULL = 3'd2,
    SRC_CTRL_STALL= 3'd3,
    SRC_RMT_FULL  = 3'd4,
    SRC_PAY_STALL = 3'd5,
    SRC_RXIN_FULL = 3'd6
  } err_src_e;
  typedef enum logic {SEL_STATUS = 1'b0, SEL_DISCARD = 1'b1} rd_sel_e;
endpackage

// File: rtl/pem_sticky.sv
module pem_sticky #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= (q[i] & ~clr) | evt[i];
    end

    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (q[i] && !clr) |=> q[i]);
    p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> q[i]);
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !evt[i]) |=> !q[i]);
  end
endmodule

// File: rtl/pem_counter.sv
module pem_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};
  logic [W-1:0] base;

  always_comb base = clr ? '0 : q;

  always_ff @(posedge clk) begin
    if (!rst_n)                  q <= '0;
    else if (inc && base != MAXV) q <= base + 1'b1;
    else                         q <= base;
  end

  p_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (q == MAXV && !clr) |=> q == MAXV);
  p_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && q != MAXV) |=> q == $past(q) + 1'b1);
  p_clr_inc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && inc) |=> q == 1);
  p_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !inc) |=> q == 0);
endmodule

// File: rtl/pem_len_check.sv
module pem_len_check #(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_valid,
  input  logic             beat_ready,
  input  logic             beat_last,
  input  logic [LEN_W-1:0] exp_len,
  output logic             reject
);
  localparam logic [LEN_W-1:0] MAXB = {LEN_W{1'b1}};
  logic [LEN_W-1:0] seen;
  logic             xfer;
  logic [LEN_W:0]   total;

  always_comb begin
    xfer   = beat_valid && beat_ready;
    total  = {1'b0, seen} + 1'b1;
    reject = xfer && beat_last && (total != {1'b0, exp_len});
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 seen <= '0;
    else if (xfer && beat_last) seen <= '0;
    else if (xfer && seen != MAXB) seen <= seen + 1'b1;
  end

  p_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> (beat_valid && beat_ready && beat_last));
  p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(beat_valid && beat_ready) |=> $stable(seen));
  p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_ready && beat_last) |=> seen == 0);
endmodule

// File: rtl/pkt_err_monitor.sv
module pkt_err_monitor
  import pem_pkg::*;
#(
  parameter int LEN_W = 6,
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSRC-1:0]    err_evt,
  input  logic               beat_valid,
  input  logic               beat_ready,
  input  logic               beat_last,
  input  logic [LEN_W-1:0]   exp_len,
  input  logic               ovf_drop,
  input  logic               rd_en,
  input  logic               rd_sel,
  output logic [2*CNT_W-1:0] rd_data,
  output logic               err_any
);
  localparam int RD_W = 2 * CNT_W;

  logic [NSRC-1:0]  status;
  logic [CNT_W-1:0] rej_cnt, ovf_cnt;
  logic             clr_stat, clr_disc, rej_pulse;

  always_comb begin
    clr_stat = rd_en && (rd_sel == SEL_STATUS);
    clr_disc = rd_en && (rd_sel == SEL_DISCARD);
  end

  pem_sticky #(.N(NSRC)) u_sticky (
    .clk(clk), .rst_n(rst_n), .evt(err_evt), .clr(clr_stat), .q(status));

  pem_len_check #(.LEN_W(LEN_W)) u_len (
    .clk(clk), .rst_n(rst_n), .beat_valid(beat_valid), .beat_ready(beat_ready),
    .beat_last(beat_last), .exp_len(exp_len), .reject(rej_pulse));

  pem_counter #(.W(CNT_W)) u_rej (
    .clk(clk), .rst_n(rst_n), .inc(rej_pulse), .clr(clr_disc), .q(rej_cnt));

  pem_counter #(.W(CNT_W)) u_ovf (
    .clk(clk), .rst_n(rst_n), .inc(ovf_drop), .clr(clr_disc), .q(ovf_cnt));

  always_comb begin
    err_any = |status;
    if (rd_sel == SEL_DISCARD) rd_data = {rej_cnt, ovf_cnt};
    else                       rd_data = {{(RD_W-NSRC){1'b0}}, status};
  end

  p_any_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_any) |-> $past(|err_evt));
  p_any_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_any) |-> $past(clr_stat));
  p_rej_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rej_pulse |=> !rej_pulse || $past(beat_valid && beat_ready && beat_last));
endmodule

// File: tb/sim_pkt_err_monitor.sv
module sim_pkt_err_monitor;
  localparam int LEN_W = 6;
  localparam int CNT_W = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic [6:0] err_evt = '0;
  logic beat_valid = 0, beat_ready = 0, beat_last = 0;
  logic [LEN_W-1:0] exp_len = '0;
  logic ovf_drop = 0, rd_en = 0, rd_sel = 0;
  logic [2*CNT_W-1:0] rd_data;
  logic err_any;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pkt_err_monitor #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .beat_valid(beat_valid),
    .beat_ready(beat_ready), .beat_last(beat_last), .exp_len(exp_len),
    .ovf_drop(ovf_drop), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
    .err_any(err_any));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic sel, output logic [2*CNT_W-1:0] d);
    @(negedge clk);
    rd_en = 1; rd_sel = sel;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic send_pkt(input int n, input bit stall);
    for (int b = 0; b < n; b++) begin
      if (stall) begin
        @(negedge clk);
        beat_valid = 1; beat_ready = 0; beat_last = (b == n - 1);
      end
      @(negedge clk);
      beat_valid = 1; beat_ready = 1; beat_last = (b == n - 1);
    end
    @(negedge clk);
    beat_valid = 0; beat_ready = 0; beat_last = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [2*CNT_W-1:0] d;
    int exp_rej;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11 err_any", err_any, 0);
    rd(0, d); chk("R11 status", d, 0);
    rd(1, d); chk("R11 counters", d, 0);

    // R1 R2 R3: every status pattern
    for (int p = 1; p < 128; p++) begin
      @(negedge clk); err_evt = p[6:0];
      @(negedge clk); err_evt = 0;
      chk("R2 any", err_any, 1);
      rd(0, d); chk("R1 R3 status", d, p);
      chk("R3 cleared any", err_any, 0);
    end
    // R1 stickiness over idle
    @(negedge clk); err_evt = 7'b0100000;
    @(negedge clk); err_evt = 0;
    repeat (10) @(negedge clk);
    rd(0, d); chk("R1 sticky", d, 32);
    rd(0, d); chk("R3 read clears", d, 0);

    // R4 event in read cycle
    @(negedge clk); err_evt = 7'b0000011;
    @(negedge clk); err_evt = 7'b1000100; rd_en = 1; rd_sel = 0;
    #1 chk("R4 old data", rd_data, 3);
    @(negedge clk); rd_en = 0; err_evt = 0;
    rd(0, d); chk("R4 survives", d, 7'b1000100);

    // R5 R6 length sweep
    for (int e = 1; e <= 5; e++) begin
      exp_len = e[LEN_W-1:0];
      exp_rej = 0;
      for (int n = 1; n <= 6; n++) begin
        send_pkt(n, (n % 2) == 0);
        if (n != e) exp_rej++;
      end
      rd(1, d); chk("R5 R6 reject sweep", d, exp_rej << CNT_W);
    end
    // R5 oversize packet always rejected
    exp_len = 6'd63;
    send_pkt(70, 0);
    send_pkt(63, 0);
    rd(1, d); chk("R5 oversize", d, 1 << CNT_W);

    // R7 R8 overflow count and pair order
    exp_len = 6'd2;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); ovf_drop = 1;
      @(negedge clk); ovf_drop = 0;
    end
    send_pkt(3, 0);
    rd(1, d); chk("R7 R8 pair", d, (1 << CNT_W) | 5);
    rd(1, d); chk("R8 read clears", d, 0);

    // R9 increments in read cycle
    @(negedge clk); ovf_drop = 1;
    @(negedge clk); ovf_drop = 1; rd_en = 1; rd_sel = 1;
    beat_valid = 1; beat_ready = 1; beat_last = 1;
    #1 chk("R9 old data", rd_data, 1);
    @(negedge clk); rd_en = 0; ovf_drop = 0;
    beat_valid = 0; beat_ready = 0; beat_last = 0;
    rd(1, d); chk("R9 survives", d, (1 << CNT_W) | 1);

    // R10 saturation
    @(negedge clk); ovf_drop = 1;
    repeat (300) @(negedge clk);
    ovf_drop = 0;
    rd(1, d); chk("R10 saturate", d, 255);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule